// File: doc/BRIEF.md
# Iterative 128-bit Feistel Block Cipher Core

This block encrypts or decrypts one 128-bit block under a 128-bit key. It has a single Feistel round stage and passes each block through it once per clock for sixteen rounds. The round function works on 64-bit halves. It combines round-key mixing, a 32-bit confusion layer built from two 8x8 substitution boxes with masked byte mixing, and additions modulo 2^32.

Key handling is a separate phase. A pulse on `keyLoad` captures a key. The key schedule then runs for sixteen cycles and writes one 64-bit round key per cycle into an internal buffer. When the schedule finishes, `keyReady` rises. Every later block reuses these stored round keys until a new key is loaded.

Decryption uses the same round stage with the buffer read in reverse order. A feedback chaining mode placed around the core therefore sees the same sixteen-cycle latency whichever direction it runs.

Top module: `feistel128_core`

## Requirements
- R1: After reset, `keyReady`, `busy` and `done` are low and `blockOut` is all zeros.
- R2: A `keyLoad` pulse accepted while the core is idle clears `keyReady`. `keyReady` is high again 16 clock edges after the accepting edge. The key schedule works as follows:
  - The key is split as A=`keyIn[127:96]`, B=`[95:64]`, C=`[63:32]`, D=`[31:0]`.
  - A constant rc starts at 32'h9E3779B9.
  - For step i from 0 to 15, round key i is {G(A+C-rc), G(B-D+rc)}, with the arithmetic modulo 2^32.
  - After each step, {A,B} rotates right by 8 bits when i is even, and {C,D} rotates left by 8 bits when i is odd. rc then rotates left by 1 bit.
- R3: A `start` while `keyReady` is low is ignored: `busy` stays low and no `done` follows.
- R4: With `decrypt`=0, the block output is defined as follows:
  - The halves are L=`blockIn[127:64]` and R=`[63:0]`.
  - Each of the 16 rounds sets L'=R and R'=L^F(R,k) with k=round key i.
  - The output is {R16, L16}.
  - F({c,d},{k0,k1}): a=c^k0, b=d^k1, t0=G(a^b), t1=G(a+t0), t2=G(t0+t1). The result is {t1+t2, t2}.
  - G(x): byte j (j=0 is bits 7:0) passes through SA when j is even and through SB when j is odd, giving y_j. Output byte z_k is the XOR over j of (y_j AND M[(j+k) mod 4]), with M = {8'hFC, 8'hF3, 8'hCF, 8'h3F}.
  - SA(x)=p^rotl(p,1)^rotl(p,3)^8'hA9 with p=x^247. SB(x)=p^rotl(p,2)^rotl(p,5)^8'h38 with p=x^251. Both powers are taken in GF(2^8) modulo x^8+x^6+x^5+x+1.
- R5: With `decrypt`=1, the rounds use round keys in the order 15 down to 0, so decrypting a ciphertext returns the original plaintext.
- R6: A start accepted at a clock edge makes `busy` high for exactly 16 cycles. `done` is high for exactly one cycle, the first cycle after `busy` falls, and `blockOut` takes the result at that same edge.
- R7: A `start` while `busy` is high is ignored: the running block's result is unchanged and only one `done` pulse occurs.
- R8: A `keyLoad` while `busy` is high or during key scheduling is ignored: the round keys in use are not replaced and `keyReady` does not change.
- R9: Round keys persist: further blocks under the same key need no new `keyLoad`.
- R10: `blockOut` changes only at the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| keyLoad | input | 1 | Capture `keyIn` and run the key schedule |
| keyIn | input | 128 | Cipher key |
| start | input | 1 | Begin processing `blockIn` |
| decrypt | input | 1 | Direction: 1 decrypts, 0 encrypts |
| blockIn | input | 128 | Input block |
| keyReady | output | 1 | Round-key buffer is valid |
| busy | output | 1 | A block is in the round stage |
| done | output | 1 | One-cycle pulse: `blockOut` is new |
| blockOut | output | 128 | Result register |

## Verification
The bound checker watches the handshake on every cycle:
- `done` lasts exactly one cycle and directly follows `busy`.
- Every busy window is exactly sixteen cycles long.
- `busy` never rises without valid round keys.
- `keyReady` cannot move while a block runs.
- `blockOut` changes only with `done`.

The cipher values themselves can only be shown by the bench's scenarios. It compares encryption against an independent model for several key and block patterns and checks that decryption round-trips. It also shows that a start or key load sent mid-run leaves the result unchanged, and that a stored key schedule survives across blocks.

// File: rtl/feistel128_pkg.sv
package feistel128_pkg;
  localparam int BLOCK_W = 128;
  localparam int HALF_W  = BLOCK_W / 2;
  localparam int WORD_W  = HALF_W / 2;
  localparam int ROUNDS  = 16;
  localparam int IDX_W   = $clog2(ROUNDS);
  localparam int SBOX_BITS = 256 * 8;
  localparam logic [WORD_W-1:0] RC_INIT = 32'h9E3779B9;
  localparam logic [WORD_W-1:0] MIX_MASKS = {8'h3F, 8'hCF, 8'hF3, 8'hFC};

  typedef struct packed {
    logic             loadKey;
    logic             keyStep;
    logic             loadBlock;
    logic             roundEn;
    logic             lastRound;
    logic [IDX_W-1:0] idx;
  } ctrlStrobe_t;

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[7] ? ((sh << 1) ^ 8'h63) : (sh << 1);
    end
    return acc;
  endfunction

  function automatic logic [7:0] gfPow(input logic [7:0] x, input logic [7:0] e);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 7; i >= 0; i--) begin
      r = gfMul(r, r);
      if (e[i]) r = gfMul(r, x);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] sboxEntry(input logic sel, input logic [7:0] x);
    logic [7:0] p;
    if (!sel) begin
      p = gfPow(x, 8'd247);
      return p ^ rotl8(p, 1) ^ rotl8(p, 3) ^ 8'hA9;
    end
    p = gfPow(x, 8'd251);
    return p ^ rotl8(p, 2) ^ rotl8(p, 5) ^ 8'h38;
  endfunction

  function automatic logic [SBOX_BITS-1:0] buildSbox(input logic sel);
    logic [SBOX_BITS-1:0] tbl;
    tbl = '0;
    for (int v = 0; v < 256; v++) tbl[8*v +: 8] = sboxEntry(sel, v[7:0]);
    return tbl;
  endfunction

  localparam logic [SBOX_BITS-1:0] SBOX_A = buildSbox(1'b0);
  localparam logic [SBOX_BITS-1:0] SBOX_B = buildSbox(1'b1);

  function automatic logic [WORD_W-1:0] gMix(input logic [WORD_W-1:0] x);
    logic [7:0] y [4];
    logic [WORD_W-1:0] z;
    for (int j = 0; j < 4; j++) begin
      if (j % 2 == 0) y[j] = SBOX_A[{x[8*j +: 8], 3'b000} +: 8];
      else            y[j] = SBOX_B[{x[8*j +: 8], 3'b000} +: 8];
    end
    z = '0;
    for (int k = 0; k < 4; k++)
      for (int j = 0; j < 4; j++)
        z[8*k +: 8] = z[8*k +: 8] ^ (y[j] & MIX_MASKS[8*((j + k) % 4) +: 8]);
    return z;
  endfunction

  function automatic logic [HALF_W-1:0] fRound(input logic [HALF_W-1:0] half,
                                               input logic [HALF_W-1:0] rk);
    logic [WORD_W-1:0] a, b, t0, t1, t2;
    a  = half[HALF_W-1:WORD_W] ^ rk[HALF_W-1:WORD_W];
    b  = half[WORD_W-1:0] ^ rk[WORD_W-1:0];
    t0 = gMix(a ^ b);
    t1 = gMix(a + t0);
    t2 = gMix(t0 + t1);
    return {t1 + t2, t2};
  endfunction
endpackage

// File: rtl/feistel128_ctrl.sv
module feistel128_ctrl
  import feistel128_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        keyLoad,
  input  logic        start,
  input  logic        decrypt,
  output ctrlStrobe_t strobe,
  output logic        keyReady,
  output logic        busy,
  output logic        done
);
  typedef enum logic [1:0] {ST_IDLE, ST_KEYGEN, ST_RUN} state_t;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ROUNDS - 1);

  state_t           state;
  logic [IDX_W-1:0] cnt;
  logic             decSel;

  always_comb begin
    strobe = '0;
    unique case (state)
      ST_IDLE: begin
        if (keyLoad)               strobe.loadKey   = 1'b1;
        else if (start && keyReady) strobe.loadBlock = 1'b1;
      end
      ST_KEYGEN: begin
        strobe.keyStep = 1'b1;
        strobe.idx     = cnt;
      end
      ST_RUN: begin
        strobe.roundEn   = 1'b1;
        strobe.lastRound = (cnt == LAST);
        strobe.idx       = decSel ? (LAST - cnt) : cnt;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      decSel   <= 1'b0;
      keyReady <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (strobe.loadKey) begin
            state    <= ST_KEYGEN;
            keyReady <= 1'b0;
          end else if (strobe.loadBlock) begin
            state  <= ST_RUN;
            decSel <= decrypt;
          end
        end
        ST_KEYGEN: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            state    <= ST_IDLE;
            keyReady <= 1'b1;
          end
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_RUN);
endmodule

// File: rtl/feistel128_dp.sv
module feistel128_dp
  import feistel128_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [BLOCK_W-1:0] keyIn,
  input  logic [BLOCK_W-1:0] blockIn,
  output logic [BLOCK_W-1:0] blockOut
);
  logic [HALF_W-1:0]  halfL, halfR;
  logic [BLOCK_W-1:0] keyWords;
  logic [WORD_W-1:0]  rc;
  logic [HALF_W-1:0]  roundKeys [ROUNDS];

  logic [WORD_W-1:0] wA, wB, wC, wD;
  logic [HALF_W-1:0] newKey, roundKey, fOut;

  assign {wA, wB, wC, wD} = keyWords;
  assign newKey   = {gMix(wA + wC - rc), gMix(wB - wD + rc)};
  assign roundKey = roundKeys[strobe.idx];
  assign fOut     = fRound(halfR, roundKey);

  always_ff @(posedge clk) begin
    if (strobe.keyStep) roundKeys[strobe.idx] <= newKey;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyWords <= '0;
      rc       <= '0;
    end else if (strobe.loadKey) begin
      keyWords <= keyIn;
      rc       <= RC_INIT;
    end else if (strobe.keyStep) begin
      if (!strobe.idx[0]) keyWords[BLOCK_W-1:HALF_W] <= {wB[7:0], wA, wB[WORD_W-1:8]};
      else                keyWords[HALF_W-1:0]       <= {wC[WORD_W-9:0], wD, wC[WORD_W-1:WORD_W-8]};
      rc <= {rc[WORD_W-2:0], rc[WORD_W-1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfL    <= '0;
      halfR    <= '0;
      blockOut <= '0;
    end else if (strobe.loadBlock) begin
      halfL <= blockIn[BLOCK_W-1:HALF_W];
      halfR <= blockIn[HALF_W-1:0];
    end else if (strobe.roundEn) begin
      halfL <= halfR;
      halfR <= halfL ^ fOut;
      if (strobe.lastRound) blockOut <= {halfL ^ fOut, halfR};
    end
  end
endmodule

// File: rtl/feistel128_core.sv
module feistel128_core
  import feistel128_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               keyLoad,
  input  logic [BLOCK_W-1:0] keyIn,
  input  logic               start,
  input  logic               decrypt,
  input  logic [BLOCK_W-1:0] blockIn,
  output logic               keyReady,
  output logic               busy,
  output logic               done,
  output logic [BLOCK_W-1:0] blockOut
);
  ctrlStrobe_t strobe;

  feistel128_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .keyLoad(keyLoad), .start(start), .decrypt(decrypt),
    .strobe(strobe), .keyReady(keyReady), .busy(busy), .done(done)
  );

  feistel128_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .keyIn(keyIn),
    .blockIn(blockIn), .blockOut(blockOut)
  );
endmodule

// File: rtl/feistel128_core_sva.sv
module feistel128_core_sva
  import feistel128_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               keyReady,
  input logic               busy,
  input logic               done,
  input logic [BLOCK_W-1:0] blockOut
);
  logic [IDX_W:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= '0;
    else       runLen <= busy ? runLen + 1'b1 : '0;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R6
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN) done |-> (!busy && $past(busy))); // R6
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rstN) $fell(busy) |-> runLen == (IDX_W+1)'(ROUNDS)); // R6
  AST_BUSY_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rstN) busy |-> keyReady); // R3
  AST_NO_START_WITHOUT_KEY: assert property (@(posedge clk) disable iff (!rstN) (start && !keyReady && !busy) |=> !busy); // R3
  AST_KEY_FROZEN_IN_RUN: assert property (@(posedge clk) disable iff (!rstN) busy |=> $stable(keyReady)); // R8
  AST_RESULT_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rstN) !$stable(blockOut) |-> done); // R10
endmodule

bind feistel128_core feistel128_core_sva u_sva (
  .clk(clk), .rstN(rstN), .start(start), .keyReady(keyReady),
  .busy(busy), .done(done), .blockOut(blockOut)
);

// File: tb/feistel128_core_test.sv
module feistel128_core_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         keyLoad = 1'b0;
  logic [127:0] keyIn = '0;
  logic         start = 1'b0;
  logic         decrypt = 1'b0;
  logic [127:0] blockIn = '0;
  logic         keyReady, busy, done;
  logic [127:0] blockOut;

  int checks = 0;
  int fails = 0;
  int donePulses = 0;
  logic [7:0] tabA [256];
  logic [7:0] tabB [256];

  always #2 clk = ~clk;

  feistel128_core uut (
    .clk(clk), .rstN(rstN), .keyLoad(keyLoad), .keyIn(keyIn), .start(start),
    .decrypt(decrypt), .blockIn(blockIn), .keyReady(keyReady), .busy(busy),
    .done(done), .blockOut(blockOut)
  );

  always @(negedge clk) if (done) donePulses++;

  localparam logic [255:0] VEC [4] = '{
    {128'h0, 128'h0},
    {128'h000102030405060708090A0B0C0D0E0F, 128'h0},
    {128'h0, 128'h00112233445566778899AABBCCDDEEFF},
    {128'hDEADBEEF0123456789ABCDEFFEEDC0DE, 128'h5A5A5A5AA5A5A5A5C3C3C3C33C3C3C3C}
  };

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent model -------------------------------------------------
  function automatic logic [7:0] mulRef(input logic [7:0] a, input logic [7:0] b);
    logic [14:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p ^= 15'(a) << i;
    for (int bt = 14; bt >= 8; bt--) if (p[bt]) p ^= 15'h163 << (bt - 8);
    return p[7:0];
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  task automatic buildTables();
    for (int v = 0; v < 256; v++) begin
      logic [7:0] pa = 8'h01, pb = 8'h01;
      for (int e = 0; e < 247; e++) pa = mulRef(pa, v[7:0]);
      for (int e = 0; e < 251; e++) pb = mulRef(pb, v[7:0]);
      tabA[v] = pa ^ rl(pa, 1) ^ rl(pa, 3) ^ 8'hA9;
      tabB[v] = pb ^ rl(pb, 2) ^ rl(pb, 5) ^ 8'h38;
    end
  endtask

  function automatic logic [31:0] gRef(input logic [31:0] x);
    logic [7:0] y [4];
    logic [7:0] m [4] = '{8'hFC, 8'hF3, 8'hCF, 8'h3F};
    logic [31:0] z = '0;
    y[0] = tabA[x[7:0]];  y[1] = tabB[x[15:8]];
    y[2] = tabA[x[23:16]]; y[3] = tabB[x[31:24]];
    for (int k = 0; k < 4; k++)
      for (int j = 0; j < 4; j++) z[8*k +: 8] ^= y[j] & m[(j + k) % 4];
    return z;
  endfunction

  function automatic logic [127:0] modelCrypt(input logic [127:0] key, input logic [127:0] blk, input bit dec);
    logic [63:0] sk [16];
    logic [31:0] a = key[127:96], b = key[95:64], c = key[63:32], d = key[31:0];
    logic [31:0] rc = 32'h9E3779B9;
    logic [63:0] l = blk[127:64], r = blk[63:0], tmp;
    for (int i = 0; i < 16; i++) begin
      logic [63:0] ab, cd;
      sk[i] = {gRef(a + c - rc), gRef(b - d + rc)};
      ab = {a, b}; cd = {c, d};
      if (i % 2 == 0) ab = {ab[7:0], ab[63:8]};
      else            cd = {cd[55:0], cd[63:56]};
      {a, b} = ab; {c, d} = cd;
      rc = {rc[30:0], rc[31]};
    end
    for (int i = 0; i < 16; i++) begin
      logic [63:0] k = dec ? sk[15 - i] : sk[i];
      logic [31:0] p = r[63:32] ^ k[63:32], q = r[31:0] ^ k[31:0];
      logic [31:0] t0, t1, t2;
      t0 = gRef(p ^ q); t1 = gRef(p + t0); t2 = gRef(t0 + t1);
      tmp = r;
      r = l ^ {t1 + t2, t2};
      l = tmp;
    end
    return {r, l};
  endfunction

  // stimulus tasks -----------------------------------------------------
  task automatic loadKeyTask(input logic [127:0] key, input int injectAt, input logic [127:0] key2);
    int n;
    @(negedge clk); keyLoad = 1'b1; keyIn = key;
    @(negedge clk); keyLoad = 1'b0;
    check(keyReady == 1'b0, "R2 keyReady low during schedule", 128'(keyReady), 128'h0);
    n = 0;
    while (!keyReady && n < 100) begin
      if (n == injectAt) begin keyLoad = 1'b1; keyIn = key2; end
      else keyLoad = 1'b0;
      @(negedge clk); n++;
    end
    keyLoad = 1'b0;
    check(n == 16, "R2 schedule length", 128'(n), 128'd16);
  endtask

  // inject kind: 0 start, 1 keyLoad
  task automatic runBlock(input logic [127:0] blk, input bit dec, input int injectAt,
                          input bit injectKind, input logic [127:0] injData,
                          output logic [127:0] res);
    int n, busyBad, startPulses;
    @(negedge clk); start = 1'b1; blockIn = blk; decrypt = dec;
    @(negedge clk); start = 1'b0;
    startPulses = donePulses;
    n = 0; busyBad = 0;
    while (!done && n < 100) begin
      if (!busy) busyBad++;
      if (n == injectAt) begin
        if (injectKind) begin keyLoad = 1'b1; keyIn = injData; end
        else begin start = 1'b1; blockIn = injData; decrypt = 1'b0; end
      end else begin
        start = 1'b0; keyLoad = 1'b0;
      end
      @(negedge clk); n++;
    end
    start = 1'b0; keyLoad = 1'b0;
    check(busyBad == 0, "R6 busy held during run", 128'(busyBad), 128'h0);
    check(n == 16, "R6 done latency", 128'(n), 128'd16);
    check(busy == 1'b0, "R6 busy low with done", 128'(busy), 128'h0);
    res = blockOut;
    @(negedge clk);
    check(done == 1'b0, "R6 done one cycle", 128'(done), 128'h0);
    check(blockOut == res, "R10 result held", blockOut, res);
    repeat (20) @(negedge clk);
    check(donePulses - startPulses == 1, "R7 single done pulse", 128'(donePulses - startPulses), 128'd1);
  endtask

  initial begin
    logic [127:0] res, exp;
    buildTables();
    repeat (3) @(negedge clk);
    check(keyReady == 0 && busy == 0 && done == 0, "R1 flags after reset",
          128'({keyReady, busy, done}), 128'h0);
    check(blockOut == '0, "R1 output after reset", blockOut, 128'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(keyReady == 0 && busy == 0 && done == 0, "R1 flags after release",
          128'({keyReady, busy, done}), 128'h0);

    // R3: start without key
    start = 1'b1; blockIn = 128'h1234;
    @(negedge clk); start = 1'b0;
    repeat (20) begin
      @(negedge clk);
      check(busy == 0 && done == 0, "R3 start before key ignored", 128'({busy, done}), 128'h0);
    end

    // main vector walk: R2, R4, R5
    for (int v = 0; v < 4; v++) begin
      logic [127:0] ct;
      loadKeyTask(VEC[v][255:128], -1, '0);
      exp = modelCrypt(VEC[v][255:128], VEC[v][127:0], 1'b0);
      runBlock(VEC[v][127:0], 1'b0, -1, 1'b0, '0, ct);
      check(ct == exp, "R4 encrypt vector", ct, exp);
      runBlock(ct, 1'b1, -1, 1'b0, '0, res);
      check(res == VEC[v][127:0], "R5 decrypt round trip", res, VEC[v][127:0]);
      exp = modelCrypt(VEC[v][255:128], ct, 1'b1);
      check(res == exp, "R5 decrypt model", res, exp);
    end

    // R9: reuse of last key, new block
    exp = modelCrypt(VEC[3][255:128], 128'hFFFF0000FFFF0000FFFF0000FFFF0000, 1'b0);
    runBlock(128'hFFFF0000FFFF0000FFFF0000FFFF0000, 1'b0, -1, 1'b0, '0, res);
    check(res == exp, "R9 key reused", res, exp);

    // R7: start during run ignored
    exp = modelCrypt(VEC[3][255:128], 128'hA5, 1'b0);
    runBlock(128'hA5, 1'b0, 5, 1'b0, 128'hBEEF, res);
    check(res == exp, "R7 mid-run start ignored", res, exp);

    // R8: keyLoad during run ignored
    exp = modelCrypt(VEC[3][255:128], 128'h77, 1'b0);
    runBlock(128'h77, 1'b0, 7, 1'b1, 128'hCAFE, res);
    check(res == exp, "R8 mid-run keyLoad ignored", res, exp);
    check(keyReady == 1'b1, "R8 keyReady kept", 128'(keyReady), 128'h1);
    exp = modelCrypt(VEC[3][255:128], 128'h88, 1'b0);
    runBlock(128'h88, 1'b0, -1, 1'b0, '0, res);
    check(res == exp, "R8 round keys not replaced", res, exp);

    // R8: keyLoad during schedule ignored
    loadKeyTask(VEC[1][255:128], 3, VEC[2][255:128]);
    exp = modelCrypt(VEC[1][255:128], 128'h99, 1'b0);
    runBlock(128'h99, 1'b0, -1, 1'b0, '0, res);
    check(res == exp, "R8 keyLoad in schedule ignored", res, exp);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule